// File: doc/BRIEF.md
# Escalating Four-Stage Watchdog

The block is a watchdog that walks through four timeout stages in turn. Each stage counts ticks of a programmable prescaled clock up to its own timeout. When a stage expires it performs its configured action and hands over to the next stage. The action is one of: nothing, an interrupt, a CPU reset pulse or a system reset pulse. After the last stage the sequence wraps to the first. Software keeps the watchdog quiet by writing to a feed address, which sends it back to the start of the first stage.

Configuration goes through a shadow copy. Writes land in shadow registers and become active only when an update command is written. A key register gates all configuration writes. The block has no data stream, so every pin is a plain control or status signal. The write port is a single-cycle strobe with no back-pressure: a write is taken on every rising edge where `wr_en` is high. The reset outputs are level pulses whose width comes from an encoded select.

Top module: `stage_watchdog`

## Requirements
- R1: After reset, all four outputs `irq_o`, `irq_raw_o`, `cpu_rst_o` and `sys_rst_o` are low. `stage_o` is 0 and `fboot_o` is 1. The active enable is 0, the prescale value is 1 and both pulse selects are 1. The stage timeouts are TMO0_RST..TMO3_RST and the key register holds 0, so the block is locked.
- R2: While enabled, a prescaler tick occurs every P clock cycles, where P is the prescale value (0 acts as 1). A stage with timeout T expires on its T-th tick (0 acts as 1). With the prescaler idle at update edge u, stage 0 expires at edge u+P*T.
- R3: Stages run in the order 0, 1, 2, 3, 0, and `stage_o` shows the current stage. On expiry, the 2-bit action code of the expiring stage is applied: 0 does nothing, 1 raises the interrupt, 2 starts a CPU reset pulse and 3 starts a system reset pulse.
- R4: A write of any data to address 6 (feed) restarts stage 0 with a zero count and clears the prescaler count. Feed is accepted while locked, and `stage_o` is 0 in the cycle after it.
- R5: The raw interrupt flag `irq_raw_o` stays set until data with bit 0 set is written to address 10; data with bit 0 clear leaves the flag unchanged. `irq_o` equals the raw flag AND the enable held in bit 0 of address 9, which is not shadowed.
- R6: Reset pulse selects 0..7 give widths of PULSE_UNIT x {1,2,3,4,5,8,16,32} clock cycles. The pulse is high from the cycle after expiry.
- R7: Address 0 holds the control word: bit 0 enable, bit 1 flash-boot flag, bits [3:2]/[5:4]/[7:6]/[9:8] the action codes of stages 0/1/2/3, bits [12:10] the CPU pulse select and bits [15:13] the system pulse select. Address 1 holds the prescale value in bits [PRE_W-1:0], and addresses 2..5 hold the stage 0..3 timeouts. Writes to these addresses have no effect until any write to address 8 copies them into the active set.
- R8: Address 7 is the key. Unless it holds UNLOCK_KEY, writes to addresses 0..5 and 8 are ignored.
- R9: Writing address 1 with bit PRE_W set clears the prescaler count at that edge, without waiting for an update.
- R10: While the active enable is 0, the stage stays at 0 and no action fires.
- R11: The active flash-boot flag is stored and driven on `fboot_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| irq_o | output | 1 | Masked interrupt |
| irq_raw_o | output | 1 | Raw interrupt flag |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |
| stage_o | output | 2 | Current stage |
| fboot_o | output | 1 | Active flash-boot flag |

## Verification
The bench builds the block with its default parameters: 32-bit timeouts, a 16-bit prescaler, a pulse unit of 8 cycles and the default key. Because timeouts and prescale values are written at run time, stages of a few ticks keep every expiry within tens of cycles. All eight pulse widths, from 8 to 256 cycles, can then be measured exactly. Short timeouts also let the bench hit the edge cases at exact cycles: a feed in mid-count, a prescaler clear one cycle after an update, and a complete wrap through all four stages.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {ACT_NONE = 2'd0, ACT_IRQ = 2'd1, ACT_CPU = 2'd2, ACT_SYS = 2'd3} act_e;

  typedef struct packed {
    logic [2:0]      sys_sel;
    logic [2:0]      cpu_sel;
    logic [3:0][1:0] act;
    logic            fboot;
    logic            en;
  } ctrl_t;

  localparam logic [3:0] ADDR_CTRL  = 4'd0;
  localparam logic [3:0] ADDR_PRESC = 4'd1;
  localparam logic [3:0] ADDR_TMO0  = 4'd2;
  localparam logic [3:0] ADDR_FEED  = 4'd6;
  localparam logic [3:0] ADDR_KEY   = 4'd7;
  localparam logic [3:0] ADDR_UPD   = 4'd8;
  localparam logic [3:0] ADDR_IEN   = 4'd9;
  localparam logic [3:0] ADDR_ICLR  = 4'd10;

  localparam logic [15:0] CTRL_RST = 16'h2402;

  function automatic int unsigned pulse_mult(input logic [2:0] sel);
    case (sel)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 5;
      3'd5: return 8;
      3'd6: return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16,
  parameter logic [31:0] UNLOCK_KEY = 32'hA5C3_0F96,
  parameter longint TMO0_RST = 26000000,
  parameter longint TMO1_RST = 134217727,
  parameter longint TMO2_RST = 1048575,
  parameter longint TMO3_RST = 1048575
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [3:0]                 wr_addr,
  input  logic [31:0]                wr_data,
  output ctrl_t                      act_ctrl,
  output logic [PRE_W-1:0]           act_presc,
  output logic [3:0][CNT_W-1:0]      act_tmo,
  output logic                       feed,
  output logic                       pre_clr,
  output logic                       irq_en,
  output logic                       irq_clr
);
  localparam logic [3:0][CNT_W-1:0] TMO_RST = {CNT_W'(TMO3_RST), CNT_W'(TMO2_RST),
                                                CNT_W'(TMO1_RST), CNT_W'(TMO0_RST)};

  logic [31:0]              key_q;
  logic                     unlocked;
  logic                     wr_ok;
  ctrl_t                    shd_ctrl;
  logic [PRE_W-1:0]         shd_presc;
  logic [3:0][CNT_W-1:0]    shd_tmo;

  assign unlocked = (key_q == UNLOCK_KEY);
  assign wr_ok    = wr_en && unlocked;
  assign feed     = wr_en && (wr_addr == ADDR_FEED);
  assign irq_clr  = wr_en && (wr_addr == ADDR_ICLR) && wr_data[0];
  assign pre_clr  = wr_ok && (wr_addr == ADDR_PRESC) && wr_data[PRE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      irq_en <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_KEY) key_q  <= wr_data;
      if (wr_addr == ADDR_IEN) irq_en <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_ctrl  <= ctrl_t'(CTRL_RST);
      shd_presc <= PRE_W'(1);
      shd_tmo   <= TMO_RST;
    end else if (wr_ok) begin
      if (wr_addr == ADDR_CTRL)  shd_ctrl  <= ctrl_t'(wr_data[15:0]);
      if (wr_addr == ADDR_PRESC) shd_presc <= wr_data[PRE_W-1:0];
      for (int i = 0; i < 4; i++)
        if (wr_addr == ADDR_TMO0 + 4'(i)) shd_tmo[i] <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ctrl  <= ctrl_t'(CTRL_RST);
      act_presc <= PRE_W'(1);
      act_tmo   <= TMO_RST;
    end else if (wr_ok && wr_addr == ADDR_UPD) begin
      act_ctrl  <= shd_ctrl;
      act_presc <= shd_presc;
      act_tmo   <= shd_tmo;
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [PRE_W-1:0]      presc,
  input  logic [3:0][CNT_W-1:0] tmo,
  input  logic [3:0][1:0]       act,
  input  logic                  feed,
  input  logic                  pre_clr,
  output logic [1:0]            stage,
  output logic                  fire_irq,
  output logic                  fire_cpu,
  output logic                  fire_sys
);
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] cnt;
  logic             tick, hit, fire;
  act_e             code;

  assign tick = en && !feed && !pre_clr &&
                ({1'b0, pre_cnt} + (PRE_W+1)'(1) >= {1'b0, presc});
  assign hit  = ({1'b0, cnt} + (CNT_W+1)'(1) >= {1'b0, tmo[stage]});
  assign fire = tick && hit;
  assign code = act_e'(act[stage]);

  assign fire_irq = fire && (code == ACT_IRQ);
  assign fire_cpu = fire && (code == ACT_CPU);
  assign fire_sys = fire && (code == ACT_SYS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pre_cnt <= '0;
    else if (!en || feed || pre_clr || tick) pre_cnt <= '0;
    else                               pre_cnt <= pre_cnt + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      stage <= 2'd0;
    end else if (!en || feed) begin
      cnt   <= '0;
      stage <= 2'd0;
    end else if (tick) begin
      if (hit) begin
        cnt   <= '0;
        stage <= stage + 2'd1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
  import wdt_pkg::*;
#(
  parameter int PULSE_UNIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] sel,
  output logic       pulse
);
  localparam int PLS_W = $clog2(PULSE_UNIT * 32 + 1);

  logic [PLS_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain <= '0;
    else if (start)            remain <= PLS_W'(PULSE_UNIT * pulse_mult(sel));
    else if (remain != '0)     remain <= remain - PLS_W'(1);
  end

  assign pulse = (remain != '0);
endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16,
  parameter int PULSE_UNIT = 8,
  parameter logic [31:0] UNLOCK_KEY = 32'hA5C3_0F96,
  parameter longint TMO0_RST = 26000000,
  parameter longint TMO1_RST = 134217727,
  parameter longint TMO2_RST = 1048575,
  parameter longint TMO3_RST = 1048575
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        irq_o,
  output logic        irq_raw_o,
  output logic        cpu_rst_o,
  output logic        sys_rst_o,
  output logic [1:0]  stage_o,
  output logic        fboot_o
);
  ctrl_t                 act_ctrl;
  logic [PRE_W-1:0]      act_presc;
  logic [3:0][CNT_W-1:0] act_tmo;
  logic                  feed, pre_clr, irq_en, irq_clr;
  logic                  fire_irq, fire_cpu, fire_sys;
  logic                  irq_raw;

  wdt_regs #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .UNLOCK_KEY(UNLOCK_KEY),
    .TMO0_RST(TMO0_RST), .TMO1_RST(TMO1_RST), .TMO2_RST(TMO2_RST), .TMO3_RST(TMO3_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .act_ctrl(act_ctrl), .act_presc(act_presc), .act_tmo(act_tmo),
    .feed(feed), .pre_clr(pre_clr), .irq_en(irq_en), .irq_clr(irq_clr)
  );

  wdt_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(act_ctrl.en), .presc(act_presc), .tmo(act_tmo),
    .act(act_ctrl.act), .feed(feed), .pre_clr(pre_clr), .stage(stage_o),
    .fire_irq(fire_irq), .fire_cpu(fire_cpu), .fire_sys(fire_sys)
  );

  wdt_pulse #(.PULSE_UNIT(PULSE_UNIT)) u_cpu_pulse (
    .clk(clk), .rst_n(rst_n), .start(fire_cpu), .sel(act_ctrl.cpu_sel), .pulse(cpu_rst_o)
  );

  wdt_pulse #(.PULSE_UNIT(PULSE_UNIT)) u_sys_pulse (
    .clk(clk), .rst_n(rst_n), .start(fire_sys), .sel(act_ctrl.sys_sel), .pulse(sys_rst_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_raw <= 1'b0;
    else if (fire_irq) irq_raw <= 1'b1;
    else if (irq_clr)  irq_raw <= 1'b0;
  end

  assign irq_raw_o = irq_raw;
  assign irq_o     = irq_raw && irq_en;
  assign fboot_o   = act_ctrl.fboot;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic       irq_o,
  input logic       irq_raw_o,
  input logic       cpu_rst_o,
  input logic       sys_rst_o,
  input logic [1:0] stage_o
);
  // R5: masked interrupt never without the raw flag
  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_raw_o);

  // R3: stages advance by one or return to 0
  a_r3_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stage_o) |-> (stage_o == $past(stage_o) + 2'd1) || (stage_o == 2'd0));

  // R4: feed returns to stage 0
  a_r4_feed_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_FEED) |=> (stage_o == 2'd0));

  // R6: CPU pulse lasts more than one cycle
  a_r6_cpu_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_o) |=> cpu_rst_o);

  // R6: system pulse lasts more than one cycle
  a_r6_sys_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |=> sys_rst_o);
endmodule

bind stage_watchdog wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .irq_o(irq_o),
  .irq_raw_o(irq_raw_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o), .stage_o(stage_o)
);

// File: tb/tb_stage_watchdog.sv
module tb_stage_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'hA5C3_0F96;
  // presc, timeout, action, select, expected delay, expected width
  localparam int unsigned VEC [9][6] = '{
    '{1, 5, 2, 0,  5,   8},
    '{3, 4, 3, 2, 12,  24},
    '{2, 7, 1, 0, 14,   0},
    '{1, 1, 2, 5,  1,  64},
    '{4, 2, 3, 7,  8, 256},
    '{1, 3, 2, 6,  3, 128},
    '{5, 3, 3, 3, 15,  32},
    '{2, 2, 2, 4,  4,  40},
    '{1, 2, 3, 1,  2,  16}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic irq_o, irq_raw_o, cpu_rst_o, sys_rst_o, fboot_o;
  logic [1:0] stage_o;
  int n_chk = 0, n_fail = 0;

  stage_watchdog dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_o(irq_o), .irq_raw_o(irq_raw_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o),
    .stage_o(stage_o), .fboot_o(fboot_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic sig(input int which);
    case (which)
      1: return irq_raw_o;
      2: return cpu_rst_o;
      default: return sys_rst_o;
    endcase
  endfunction

  task automatic measure(input int which, input int start, output int dly, output int wid);
    dly = start;
    while (!sig(which) && dly < 3000) begin @(negedge clk); dly++; end
    wid = 0;
    while (sig(which) && wid < 1000) begin @(negedge clk); wid++; end
  endtask

  task automatic quiesce();
    wr(4'd0, 32'h2);
    wr(4'd8, 0);
    wr(4'd10, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d, w;
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq_o, 0);
    check("R1 irq_raw", irq_raw_o, 0);
    check("R1 cpu", cpu_rst_o, 0);
    check("R1 sys", sys_rst_o, 0);
    check("R1 stage", stage_o, 0);
    check("R1 fboot", fboot_o, 1);

    // R8 locked at reset: config writes ignored
    wr(4'd2, 2);
    wr(4'd0, 32'h3 | (3 << 2));
    wr(4'd8, 0);
    seen = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); seen |= sys_rst_o | (stage_o != 0); end
    check("R8 locked writes ignored", seen, 0);

    wr(4'd7, KEY);

    // R2 R3 R6 vector table
    foreach (VEC[i]) begin
      quiesce();
      wr(4'd1, VEC[i][0]);
      wr(4'd2, VEC[i][1]);
      for (int s = 3; s < 6; s++) wr(4'(s), 1000);
      wr(4'd0, 32'h3 | (VEC[i][2] << 2) | (VEC[i][3] << 10) | (VEC[i][3] << 13));
      wr(4'd8, 0);
      measure(int'(VEC[i][2]), 0, d, w);
      check($sformatf("R2 delay vec%0d", i), d, VEC[i][4]);
      if (VEC[i][5] != 0) check($sformatf("R6 width vec%0d", i), w, VEC[i][5]);
      else check($sformatf("R3 irq held vec%0d", i), irq_raw_o, 1);
    end

    // R7 shadow: no effect before update
    quiesce();
    wr(4'd1, 1);
    wr(4'd2, 2);
    wr(4'd0, 32'h3 | (2 << 2));
    seen = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); seen |= cpu_rst_o | (stage_o != 0); end
    check("R7 no effect before update", seen, 0);
    wr(4'd8, 0);
    measure(2, 0, d, w);
    check("R7 delay after update", d, 2);

    // R3 full escalation: tmo 2,3,4,5 acts 1,0,2,3, selects 0
    quiesce();
    wr(4'd1, 1);
    for (int s = 0; s < 4; s++) wr(4'(2 + s), 2 + s);
    wr(4'd0, 32'h3 | (1 << 2) | (0 << 4) | (2 << 6) | (3 << 8));
    wr(4'd8, 0);
    for (int k = 0; k < 16; k++) begin
      int e;
      e = (k < 2) ? 0 : (k < 5) ? 1 : (k < 9) ? 2 : (k < 14) ? 3 : 0;
      check($sformatf("R3 stage k=%0d", k), stage_o, e);
      if (k == 1)  check("R3 irq before", irq_raw_o, 0);
      if (k == 2)  check("R3 irq stage0", irq_raw_o, 1);
      if (k == 8)  check("R3 cpu before", cpu_rst_o, 0);
      if (k == 9)  check("R3 cpu stage2", cpu_rst_o, 1);
      if (k == 13) check("R3 sys before", sys_rst_o, 0);
      if (k == 14) check("R3 sys stage3", sys_rst_o, 1);
      @(negedge clk);
    end

    // R5 interrupt mask and clear
    wr(4'd0, 32'h2);
    wr(4'd8, 0);
    check("R5 raw held", irq_raw_o, 1);
    check("R5 masked off", irq_o, 0);
    wr(4'd9, 1);
    check("R5 masked on", irq_o, 1);
    wr(4'd10, 0);
    check("R5 clear bit0=0 ignored", irq_raw_o, 1);
    wr(4'd10, 1);
    check("R5 cleared raw", irq_raw_o, 0);
    check("R5 cleared irq", irq_o, 0);

    // R4 feed, accepted while locked
    quiesce();
    wr(4'd1, 1);
    wr(4'd2, 6);
    wr(4'd0, 32'h3 | (3 << 2));
    wr(4'd8, 0);
    wr(4'd7, 0);
    wr(4'd6, 32'h1234);
    check("R4 stage after feed", stage_o, 0);
    measure(3, 0, d, w);
    check("R4 delay after feed", d, 6);
    wr(4'd7, KEY);

    // R9 prescaler count clear
    quiesce();
    wr(4'd1, 4);
    wr(4'd2, 1);
    wr(4'd0, 32'h3 | (2 << 2));
    wr(4'd8, 0);
    wr(4'd1, 32'h1_0004);
    measure(2, 1, d, w);
    check("R9 delay with prescaler clear", d, 5);

    // R10 disabled: no action
    quiesce();
    wr(4'd2, 1);
    wr(4'd0, 32'h2 | (3 << 2));
    wr(4'd8, 0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); seen |= sys_rst_o | (stage_o != 0); end
    check("R10 disabled quiet", seen, 0);

    // R11 flash-boot flag
    wr(4'd0, 32'h0);
    check("R11 fboot before update", fboot_o, 1);
    wr(4'd8, 0);
    check("R11 fboot after update", fboot_o, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule